// File: doc/BRIEF.md
# Limit-Bounded Digital Ramp Generator

This block produces a 32-bit ramp value that climbs or descends between a programmable floor and ceiling. An external direction input chooses the slope: while it is high the value grows by an up-step once every P clock cycles, and while it is low the value shrinks by a down-step once every N clock cycles. When the value reaches the limit it is heading towards, it parks there. If that limit is then moved past it, the ramp carries on. A hold input freezes the value in place. A level clear and a one-cycle auto-clear force the value back to the floor.

All settings go into shadow registers through a simple write port. These settings are the enable, clear and auto-clear bits, both limits, both step sizes and both rate intervals. An update strobe copies the whole shadow set into the active set in one transfer, so a set of changes takes effect together. An update is sampled on a rising clock edge, and the new active settings act on the ramp from the next edge. A flag reports each cycle in which the ramp is pinned against the limit in its current direction.

Top module: `ramp_gen_lim`

## Requirements
- R1: A write (`cfg_we`, `cfg_addr`, `cfg_wdata`) changes only the shadow set. The ramp is unaffected until `upd` is sampled high, and that edge copies the complete shadow set into the active set. Address map: 0 = control (bit 0 enable, bit 1 clear, bit 2 auto-clear), 1 = floor, 2 = ceiling, 3 = up-step, 4 = down-step, 5 = intervals (P in bits 15:0, N in bits 31:16).
- R2: On the first edge after the update that sets enable, a low `dir` loads `ramp_out` with the floor. A high `dir` makes the ramp take its first upward step from its present value on that same edge.
- R3: While enabled and running, each step adds the up-step when `dir` is 1 and subtracts the down-step when `dir` is 0.
- R4: A rising ramp stops at the ceiling and stays there. If the ceiling is raised, rising resumes at the next step.
- R5: A falling ramp stops at the floor and stays there. If the floor is lowered, falling resumes at the next step.
- R6: While `hold` is 1 the value does not change. When `hold` returns to 0, stepping resumes with the same slope.
- R7: While the active clear bit is 1, `ramp_out` equals the floor on every edge. Once an update makes the bit 0, stepping restarts on the following edge.
- R8: An update that copies an auto-clear bit of 1 forces `ramp_out` to the floor for exactly one edge, after which ramping continues. The bit stays set, and every later update that carries it produces another one-cycle clear.
- R9: Up-steps occur every P cycles and down-steps every N cycles, with 0 or 1 meaning every cycle. A change of `dir` restarts the interval count, so the first step in the new direction lands on the P-th or N-th edge.
- R10: `at_limit` is 1 exactly when enabled and `ramp_out` equals the ceiling with `dir` high, or equals the floor with `dir` low.
- R11: A synchronous active-high `rst` clears the shadow and active sets and drives `ramp_out` to 0 and `at_limit` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Shadow register write strobe |
| cfg_addr | input | 3 | Shadow register select |
| cfg_wdata | input | 32 | Shadow register write data |
| upd | input | 1 | Update strobe, shadow to active transfer |
| dir | input | 1 | Slope direction, 1 = rising |
| hold | input | 1 | Freeze the ramp |
| ramp_out | output | 32 | Ramp value |
| at_limit | output | 1 | Ramp pinned at the limit of its direction |

## Verification
A fault in the active settings or the update path shows at the ports as a ramp value that moves one edge too early or too late around an update. Because the value is checked on every edge, such a fault is caught in the first cycle it occurs. A fault in the interval counter shows as a staircase with the wrong spacing, and the damage appears within one interval after a direction change. A fault in saturation or clear priority shows as a value past a limit or a missing one-edge drop to the floor. Both are seen on the edge the condition arises, and the pinned flag exposes a wrong comparison in the same cycle.

// File: rtl/ramp_pkg.sv
package ramp_pkg;

    parameter int unsigned RAMP_W  = 32;
    parameter int unsigned RATE_W  = 16;
    parameter int unsigned ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_LO   = 3'd1;
    localparam logic [ADDR_W-1:0] A_HI   = 3'd2;
    localparam logic [ADDR_W-1:0] A_UP   = 3'd3;
    localparam logic [ADDR_W-1:0] A_DN   = 3'd4;
    localparam logic [ADDR_W-1:0] A_RATE = 3'd5;

    typedef logic [RAMP_W-1:0] ramp_t;
    typedef logic [RATE_W-1:0] rate_t;

    typedef struct packed {
        logic  en;
        logic  clr;
        logic  aclr;
        ramp_t lo;
        ramp_t hi;
        ramp_t up;
        ramp_t dn;
        rate_t p;
        rate_t n;
    } ramp_cfg_t;

    localparam ramp_cfg_t CFG_RESET = '0;

    // step towards the ceiling, never past it
    function automatic ramp_t step_rise(ramp_t cur, ramp_t ceil, ramp_t inc);
        if (cur >= ceil)
            return ceil;
        else if ((ceil - cur) <= inc)
            return ceil;
        else
            return cur + inc;
    endfunction

    // step towards the floor, never past it
    function automatic ramp_t step_fall(ramp_t cur, ramp_t flr, ramp_t dec);
        if (cur <= flr)
            return flr;
        else if ((cur - flr) <= dec)
            return flr;
        else
            return cur - dec;
    endfunction

    // interval of zero behaves as one
    function automatic rate_t rate_load(rate_t v);
        return (v == '0) ? rate_t'(1) : v;
    endfunction

endpackage

// File: rtl/ramp_shadow_bank.sv
module ramp_shadow_bank
    import ramp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [RAMP_W-1:0] cfg_wdata,
    input  logic              upd,
    output ramp_cfg_t         act,
    output logic              aclr_pulse,
    output logic              start_pulse
);

    ramp_cfg_t shd;

    always_ff @(posedge clk) begin
        if (rst) begin
            shd <= CFG_RESET;
        end else if (cfg_we) begin
            case (cfg_addr)
                A_CTRL: begin
                    shd.en   <= cfg_wdata[0];
                    shd.clr  <= cfg_wdata[1];
                    shd.aclr <= cfg_wdata[2];
                end
                A_LO:   shd.lo <= cfg_wdata;
                A_HI:   shd.hi <= cfg_wdata;
                A_UP:   shd.up <= cfg_wdata;
                A_DN:   shd.dn <= cfg_wdata;
                A_RATE: begin
                    shd.p <= cfg_wdata[RATE_W-1:0];
                    shd.n <= cfg_wdata[2*RATE_W-1:RATE_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act         <= CFG_RESET;
            aclr_pulse  <= 1'b0;
            start_pulse <= 1'b0;
        end else begin
            aclr_pulse  <= upd & shd.aclr;
            start_pulse <= upd & shd.en & ~act.en;
            if (upd)
                act <= shd;
        end
    end

    // R1
    act_only_on_upd_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(upd) |-> $stable(act));

    // R8
    aclr_from_upd_chk: assert property (@(posedge clk) disable iff (rst)
        aclr_pulse |-> ($past(upd) && act.aclr));

endmodule

// File: rtl/ramp_rate_timer.sv
module ramp_rate_timer
    import ramp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  logic  reload,
    input  logic  dir,
    input  rate_t p_int,
    input  rate_t n_int,
    output logic  tick
);

    rate_t cnt_q;
    logic  dir_q;
    rate_t load_v;
    rate_t eff;

    always_comb begin
        load_v = dir ? rate_load(p_int) : rate_load(n_int);
        eff    = ((dir != dir_q) || (cnt_q == '0)) ? load_v : cnt_q;
        tick   = run && (eff == rate_t'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
        end else if (reload) begin
            cnt_q <= '0;
            dir_q <= dir;
        end else if (run) begin
            cnt_q <= tick ? load_v : eff - rate_t'(1);
            dir_q <= dir;
        end
    end

    // R9
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !reload && tick && (load_v > rate_t'(1)) && dir == $past(dir) && $past(run))
            |=> !tick || reload || !run || (dir != $past(dir)));

endmodule

// File: rtl/ramp_accum.sv
module ramp_accum
    import ramp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  clr_any,
    input  logic  start,
    input  logic  dir,
    input  logic  hold,
    input  logic  tick,
    input  ramp_t lo,
    input  ramp_t hi,
    input  ramp_t up,
    input  ramp_t dn,
    output ramp_t acc_q,
    output logic  at_limit
);

    ramp_t acc_d;

    always_comb begin
        acc_d = acc_q;
        if (!en)
            acc_d = acc_q;
        else if (clr_any)
            acc_d = lo;
        else if (start && !dir)
            acc_d = lo;
        else if (hold)
            acc_d = acc_q;
        else if (tick)
            acc_d = dir ? step_rise(acc_q, hi, up) : step_fall(acc_q, lo, dn);
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else
            acc_q <= acc_d;
    end

    assign at_limit = en && (dir ? (acc_q == hi) : (acc_q == lo));

    // R4
    ceil_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !clr_any && !start && !hold && tick && dir && acc_q <= hi)
            |=> acc_q <= $past(hi));

    // R6
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !clr_any && !(start && !dir) && hold) |=> $stable(acc_q));

    // R7
    clr_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (en && clr_any) |=> acc_q == $past(lo));

endmodule

// File: rtl/ramp_gen_lim.sv
module ramp_gen_lim
    import ramp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [RAMP_W-1:0] cfg_wdata,
    input  logic              upd,
    input  logic              dir,
    input  logic              hold,
    output logic [RAMP_W-1:0] ramp_out,
    output logic              at_limit
);

    ramp_cfg_t act;
    logic      aclr_pulse;
    logic      start_pulse;
    logic      clr_any;
    logic      run;
    logic      reload;
    logic      tick;

    ramp_shadow_bank u_bank (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .upd         (upd),
        .act         (act),
        .aclr_pulse  (aclr_pulse),
        .start_pulse (start_pulse)
    );

    assign clr_any = act.clr | aclr_pulse;
    assign reload  = ~act.en | clr_any;
    assign run     = act.en & ~clr_any & ~hold;

    ramp_rate_timer u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .reload (reload),
        .dir    (dir),
        .p_int  (act.p),
        .n_int  (act.n),
        .tick   (tick)
    );

    ramp_accum u_acc (
        .clk      (clk),
        .rst      (rst),
        .en       (act.en),
        .clr_any  (clr_any),
        .start    (start_pulse),
        .dir      (dir),
        .hold     (hold),
        .tick     (tick),
        .lo       (act.lo),
        .hi       (act.hi),
        .up       (act.up),
        .dn       (act.dn),
        .acc_q    (ramp_out),
        .at_limit (at_limit)
    );

    // R11
    reset_zero_chk: assert property (@(posedge clk)
        $past(rst) |-> (ramp_out == '0));

endmodule

// File: tb/sim_ramp_gen_lim.sv
module sim_ramp_gen_lim;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        upd = 1'b0;
    logic        dir = 1'b0;
    logic        hold = 1'b0;
    logic [31:0] ramp_out;
    logic        at_limit;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ramp_gen_lim u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .upd(upd), .dir(dir), .hold(hold),
        .ramp_out(ramp_out), .at_limit(at_limit)
    );

    task automatic tick1();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] got, logic [31:0] want);
        n_vec++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, want);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick1();
        cfg_we = 1'b0;
    endtask

    task automatic do_upd();
        upd = 1'b1;
        tick1();
        upd = 1'b0;
    endtask

    // R11 reset state
    task automatic t_reset();
        rst = 1'b1; tick1(); tick1();
        chk("R11 out", ramp_out, 0);
        chk("R11 flag", {31'd0, at_limit}, 0);
        rst = 1'b0;
    endtask

    // R1 shadow, R2 start low, R5 floor park, R10
    task automatic t_setup_start();
        dir = 1'b0;
        wr(3'd1, 100); wr(3'd2, 200); wr(3'd3, 10); wr(3'd4, 5);
        wr(3'd5, {16'd1, 16'd1});
        wr(3'd0, 32'h1);
        tick1(); tick1();
        chk("R1 no effect before update", ramp_out, 0);
        do_upd();
        chk("R1 update edge", ramp_out, 0);
        tick1();
        chk("R2 start low loads floor", ramp_out, 100);
        chk("R10 flag at floor", {31'd0, at_limit}, 1);
        tick1();
        chk("R5 park at floor", ramp_out, 100);
    endtask

    // R3 rise, R4 ceiling, R10
    task automatic t_rise();
        dir = 1'b1;
        for (int i = 1; i <= 10; i++) begin
            tick1();
            chk("R3 rise step", ramp_out, 100 + 10 * i);
            if (i == 1) chk("R10 flag clear mid ramp", {31'd0, at_limit}, 0);
        end
        tick1();
        chk("R4 park at ceiling", ramp_out, 200);
        chk("R10 flag at ceiling", {31'd0, at_limit}, 1);
        wr(3'd2, 230);
        chk("R4 ceiling write no effect", ramp_out, 200);
        do_upd();
        chk("R4 update edge", ramp_out, 200);
        tick1(); chk("R4 resume", ramp_out, 210);
        tick1(); chk("R4 resume", ramp_out, 220);
        tick1(); chk("R4 resume", ramp_out, 230);
        tick1(); chk("R4 new ceiling", ramp_out, 230);
    endtask

    // R3 fall, R5 floor and lowering
    task automatic t_fall();
        dir = 1'b0;
        for (int i = 1; i <= 26; i++) begin
            tick1();
            chk("R3 fall step", ramp_out, 230 - 5 * i);
        end
        tick1();
        chk("R5 park at floor", ramp_out, 100);
        chk("R10 flag at floor", {31'd0, at_limit}, 1);
        wr(3'd1, 90);
        do_upd();
        chk("R5 update edge", ramp_out, 100);
        tick1(); chk("R5 resume", ramp_out, 95);
        tick1(); chk("R5 new floor", ramp_out, 90);
        tick1(); chk("R5 new floor", ramp_out, 90);
    endtask

    // R6 hold
    task automatic t_hold();
        dir = 1'b1;
        tick1(); chk("R6 pre", ramp_out, 100);
        tick1(); chk("R6 pre", ramp_out, 110);
        hold = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick1(); chk("R6 frozen", ramp_out, 110);
        end
        hold = 1'b0;
        tick1(); chk("R6 resume", ramp_out, 120);
    endtask

    // R7 clear
    task automatic t_clear();
        wr(3'd0, 32'h3);
        chk("R1 clear bit not yet active", ramp_out, 130);
        do_upd();
        chk("R7 update edge", ramp_out, 140);
        for (int i = 0; i < 3; i++) begin
            tick1(); chk("R7 held at floor", ramp_out, 90);
        end
        wr(3'd0, 32'h1);
        chk("R7 still clear", ramp_out, 90);
        do_upd();
        chk("R7 release edge", ramp_out, 90);
        tick1(); chk("R7 restart", ramp_out, 100);
    endtask

    // R8 auto-clear
    task automatic t_aclr();
        wr(3'd0, 32'h5);
        chk("R1 aclr not yet active", ramp_out, 110);
        do_upd();
        chk("R8 update edge", ramp_out, 120);
        tick1(); chk("R8 one cycle floor", ramp_out, 90);
        tick1(); chk("R8 continue", ramp_out, 100);
        tick1(); chk("R8 no repeat without update", ramp_out, 110);
        do_upd();
        chk("R8 second update edge", ramp_out, 120);
        tick1(); chk("R8 repeat floor", ramp_out, 90);
        tick1(); chk("R8 continue", ramp_out, 100);
        wr(3'd0, 32'h1);
        chk("R8 after write", ramp_out, 110);
    endtask

    // R9 intervals P=3 N=2
    task automatic t_rate();
        wr(3'd5, {16'd2, 16'd3});
        chk("R9 pre", ramp_out, 120);
        do_upd();
        chk("R9 update edge", ramp_out, 130);
        dir = 1'b0;
        tick1(); chk("R9 N wait", ramp_out, 130);
        tick1(); chk("R9 N step", ramp_out, 125);
        tick1(); chk("R9 N wait", ramp_out, 125);
        tick1(); chk("R9 N step", ramp_out, 120);
        dir = 1'b1;
        tick1(); chk("R9 P wait", ramp_out, 120);
        tick1(); chk("R9 P wait", ramp_out, 120);
        tick1(); chk("R9 P step", ramp_out, 130);
    endtask

    // R11 and R2 start high
    task automatic t_start_high();
        t_reset();
        dir = 1'b1;
        wr(3'd2, 50); wr(3'd3, 10);
        wr(3'd0, 32'h1);
        do_upd();
        chk("R2 update edge", ramp_out, 0);
        for (int i = 1; i <= 5; i++) begin
            tick1(); chk("R2 start high rises", ramp_out, 10 * i);
        end
        tick1(); chk("R4 ceiling", ramp_out, 50);
    endtask

    initial begin
        t_reset();
        t_setup_start();
        t_rise();
        t_fall();
        t_hold();
        t_clear();
        t_aclr();
        t_rate();
        t_start_high();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule